// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a forward-mapped, two-level page table held in memory. Pages are 1 KB, so the low 10 address bits pass through as the page offset. The upper 22 bits form the page number: its top 12 bits index the outer table, and its next 10 bits index an inner table.

A requester presents an address and a write flag when the walker is ready. The walker takes the outer table base from a base-register input and reads the outer entry. If that entry permits the access, the walker reads the inner entry from the table the outer entry points to. It then returns either the frame number joined with the offset, or a fault code.

Toward memory the walker has a simple read port. Each read is a one-cycle strobe with an address, and only one read is outstanding at a time. The response is a valid pulse with data, and it may arrive after any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, and `rsp_valid` and `mem_rd` are 0.
- R2: The first memory read of a walk uses address `{ptbr, 10'b0} + {vaddr[31:20], 2'b00}` (32-bit sum, carry dropped). `ptbr` is sampled when the request is accepted.
- R3: Once the outer entry passes its checks, exactly one more read is issued, at address `{outer[31:10], 10'b0} + {vaddr[19:10], 2'b00}`. It is not issued before the outer response has arrived.
- R4: An entry holds a valid flag in bit 0, a writable flag in bit 1 and a table base or frame number in bits 31:10. On success `rsp_fault` is 0 and `rsp_paddr` is `{inner[31:10], vaddr[9:0]}`.
- R5: An outer entry with bit 0 clear ends the walk with `rsp_fault` = 1 and `rsp_paddr` = 0, and no inner read is made.
- R6: An inner entry with bit 0 clear ends the walk with `rsp_fault` = 2 and `rsp_paddr` = 0.
- R7: On a write request, a valid entry at either level with bit 1 clear ends the walk with `rsp_fault` = 3 and `rsp_paddr` = 0. A read-only outer entry stops the walk before any inner read. Read requests ignore bit 1.
- R8: `mem_rd` is high for exactly one cycle per read, and no new strobe is issued until the response has arrived. A `mem_rvalid` pulse arriving while no read is pending has no effect.
- R9: A request is accepted only when `req_ready` is 1, and `req_ready` drops in the cycle after acceptance. `req_valid` during a walk is ignored. `rsp_valid` lasts one cycle, and `req_ready` is 1 in the following cycle.
- R10: Translation results do not depend on memory response latency, from one cycle upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 22 | Outer table base, in 1 KB units |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | Access is a write |
| req_ready | output | 1 | Walker idle and able to accept |
| rsp_valid | output | 1 | Result present for one cycle |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 ok, 1 outer invalid, 2 inner invalid, 3 write to read-only |
| mem_rd | output | 1 | Read strobe toward memory |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
Assertions check on every cycle the handshake rules:
- the one-cycle read strobe and the single outstanding read;
- a stable read address while a read is pending;
- the one-cycle response;
- the drop of `req_ready` after acceptance;
- zero physical address on faults;
- offset pass-through on success.

Only the bench's scenarios can show the rest:
- the entry addresses computed at each level;
- the choice of fault code;
- that a failed outer entry skips the inner read;
- that stray responses and requests made mid-walk leave results unchanged;
- that random latencies change nothing.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int OUTER_W = 12,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [OUTER_W+INNER_W-1:0]       ptbr,
  input  logic                             req_valid,
  input  logic [OUTER_W+INNER_W+OFF_W-1:0] req_vaddr,
  input  logic                             req_write,
  output logic                             req_ready,
  output logic                             rsp_valid,
  output logic [OUTER_W+INNER_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]                       rsp_fault,
  output logic                             mem_rd,
  output logic [OUTER_W+INNER_W+OFF_W-1:0] mem_addr,
  input  logic                             mem_rvalid,
  input  logic [OUTER_W+INNER_W+OFF_W-1:0] mem_rdata
);
  localparam int VA_W = OUTER_W + INNER_W + OFF_W;
  localparam int FR_W = VA_W - OFF_W;
  localparam logic [1:0] F_OK = 2'd0, F_OUTER = 2'd1, F_INNER = 2'd2, F_PROT = 2'd3;

  typedef enum logic [1:0] {IDLE, READ_OUTER, READ_INNER, DONE} state_t;

  state_t            state;
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic              issued;
  logic [FR_W-1:0]   tbl_q;
  logic [VA_W-1:0]   paddr_q;
  logic [1:0]        fault_q;
  logic [VA_W-1:0]   idx_off;
  logic              got, ent_v, ent_w;

  assign req_ready = (state == IDLE);
  assign rsp_valid = (state == DONE);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;

  assign idx_off = (state == READ_INNER) ? VA_W'({va_q[OFF_W +: INNER_W], 2'b00})
                                         : VA_W'({va_q[VA_W-1 -: OUTER_W], 2'b00});
  assign mem_addr = {tbl_q, {OFF_W{1'b0}}} + idx_off;
  assign mem_rd   = (state == READ_OUTER || state == READ_INNER) && !issued;
  assign got      = issued && mem_rvalid;
  assign ent_v    = mem_rdata[0];
  assign ent_w    = mem_rdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      issued  <= 1'b0;
      tbl_q   <= '0;
      paddr_q <= '0;
      fault_q <= F_OK;
    end else begin
      if (mem_rd) issued <= 1'b1;
      else if (got) issued <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          tbl_q <= ptbr;
          state <= READ_OUTER;
        end
        READ_OUTER: if (got) begin
          if (!ent_v) begin
            fault_q <= F_OUTER;
            paddr_q <= '0;
            state   <= DONE;
          end else if (wr_q && !ent_w) begin
            fault_q <= F_PROT;
            paddr_q <= '0;
            state   <= DONE;
          end else begin
            tbl_q <= mem_rdata[VA_W-1:OFF_W];
            state <= READ_INNER;
          end
        end
        READ_INNER: if (got) begin
          if (!ent_v) begin
            fault_q <= F_INNER;
            paddr_q <= '0;
          end else if (wr_q && !ent_w) begin
            fault_q <= F_PROT;
            paddr_q <= '0;
          end else begin
            fault_q <= F_OK;
            paddr_q <= {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
          end
          state <= DONE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);                                                       // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && !mem_rvalid) |=> $stable(mem_addr));                            // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));                                  // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);                                  // R9
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != F_OK) |-> (rsp_paddr == '0));                   // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == F_OK) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0])); // R4
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [21:0] ptbr;
  logic        req_valid, req_write;
  logic [31:0] req_vaddr;
  logic        req_ready, rsp_valid, mem_rd, mem_rvalid;
  logic [31:0] rsp_paddr, mem_addr, mem_rdata;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int nreads = 0;
  logic [31:0] rd_addr [2];
  bit spur_req = 1'b0;
  logic [31:0] pmem [logic [31:0]];

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mk_pte(input logic [21:0] b, input bit w, input bit v);
    return {b, 8'h00, w, v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    @(negedge clk);
    forever begin
      if (mem_rd) begin
        logic [31:0] a;
        a = mem_addr;
        if (nreads < 2) rd_addr[nreads] = a;
        nreads++;
        repeat ($urandom_range(1, 4)) @(negedge clk);
        mem_rdata  = rdm(a);
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = 32'hDEAD_BEEF;
      end else if (spur_req) begin
        mem_rdata  = 32'hFFFF_FFFF;
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        spur_req   = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  task automatic walk(input logic [31:0] va, input bit wr, input bit poke);
    logic [31:0] a1, a2, e1, e2, exp_pa;
    logic [1:0]  exp_f;
    int          exp_n, t;
    a1 = {ptbr, 10'b0} + {20'b0, va[31:20], 2'b00};
    e1 = rdm(a1);
    a2 = '0;
    exp_pa = '0;
    exp_n = 1;
    if (!e1[0]) exp_f = 2'd1;
    else if (wr && !e1[1]) exp_f = 2'd3;
    else begin
      a2 = {e1[31:10], 10'b0} + {20'b0, va[19:10], 2'b00};
      e2 = rdm(a2);
      exp_n = 2;
      if (!e2[0]) exp_f = 2'd2;
      else if (wr && !e2[1]) exp_f = 2'd3;
      else begin
        exp_f = 2'd0;
        exp_pa = {e2[31:10], va[9:0]};
      end
    end
    while (!req_ready) @(negedge clk);
    nreads = 0;
    req_vaddr = va;
    req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 busy after accept", {31'b0, req_ready}, 32'h0);
    req_valid = poke;
    req_vaddr = ~va;
    req_write = ~wr;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(rsp_valid == 1'b1, "R10 response arrives", {31'b0, rsp_valid}, 32'h1);
    chk(rsp_fault == exp_f, exp_f == 0 ? "R4 fault code" : exp_f == 1 ? "R5 fault code" :
        exp_f == 2 ? "R6 fault code" : "R7 fault code", {30'b0, rsp_fault}, {30'b0, exp_f});
    chk(rsp_paddr == exp_pa, exp_f == 0 ? "R4 physical address" : "R5 R6 R7 zero address",
        rsp_paddr, exp_pa);
    chk(nreads == exp_n, exp_n == 1 ? "R5 R7 no inner read" : "R3 inner read made",
        nreads, exp_n);
    chk(rd_addr[0] == a1, "R2 outer entry address", rd_addr[0], a1);
    if (exp_n == 2) chk(rd_addr[1] == a2, "R3 inner entry address", rd_addr[1], a2);
    if (poke) chk(1'b1, "R9 mid-walk request ignored", 0, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 one-cycle response then ready",
        {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  task automatic setup(input logic [31:0] va, input bit ov, input bit ow,
                       input logic [21:0] ib, input bit iv, input bit iw, input logic [21:0] fr);
    logic [31:0] a1, a2;
    a1 = {ptbr, 10'b0} + {20'b0, va[31:20], 2'b00};
    pmem[a1] = mk_pte(ib, ow, ov);
    a2 = {ib, 10'b0} + {20'b0, va[19:10], 2'b00};
    pmem[a2] = mk_pte(fr, iw, iv);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    ptbr = 22'h000100;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_write = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd == 1'b0, "R1 reset outputs",
        {29'b0, req_ready, rsp_valid, mem_rd}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd == 1'b0, "R1 after reset",
        {29'b0, req_ready, rsp_valid, mem_rd}, 32'h4);

    // R4 successful read and write
    setup(32'h0148_D555, 1, 1, 22'h000200, 1, 1, 22'h12345);
    walk(32'h0148_D555, 0, 0);
    walk(32'h0148_D555, 1, 0);
    // R7 read through read-only entries succeeds, writes trap
    setup(32'h0230_0000, 1, 1, 22'h000300, 1, 0, 22'h0ABCD);
    walk(32'h0230_0000, 0, 0);
    walk(32'h0230_0000, 1, 0);
    setup(32'h0340_03FF, 1, 0, 22'h000400, 1, 1, 22'h3FFFF);
    walk(32'h0340_03FF, 1, 0);
    walk(32'h0340_03FF, 0, 0);
    // R5 outer invalid, R6 inner invalid
    setup(32'h0450_0000, 0, 1, 22'h000500, 1, 1, 22'h00001);
    walk(32'h0450_0000, 0, 0);
    setup(32'h0560_0000, 1, 1, 22'h000600, 0, 1, 22'h00002);
    walk(32'h0560_0000, 0, 0);
    // offset and index extremes, base wrap
    setup(32'h0000_0000, 1, 1, 22'h3FFFFF, 1, 1, 22'h00003);
    walk(32'h0000_0000, 0, 0);
    ptbr = 22'h3FFFFF;
    setup(32'hFFFF_FFFF, 1, 1, 22'h3FFFFF, 1, 1, 22'h3FFFFF);
    walk(32'hFFFF_FFFF, 1, 0);
    ptbr = 22'h000100;
    // R8 stray response while idle
    spur_req = 1'b1;
    while (spur_req) @(negedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R8 stray response ignored",
        {30'b0, req_ready, rsp_valid}, 32'h2);
    walk(32'h0148_D555, 0, 0);
    // R9 requests during a walk
    walk(32'h0560_0000, 0, 1);
    walk(32'h0148_D555, 1, 1);

    // R10 random traffic with random latency
    for (int i = 0; i < 150; i++) begin
      logic [31:0] va;
      va = $urandom;
      ptbr = 22'($urandom);
      setup(va, ($urandom % 8) != 0, ($urandom % 4) != 0, 22'($urandom),
            ($urandom % 8) != 0, ($urandom % 4) != 0, 22'($urandom));
      walk(va, 1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule